// File: doc/BRIEF.md
# Accumulator Execution Unit with Carry and Zero Status

This block is the execute stage of a small 8-bit accumulator machine. The decoder in front of it supplies an operation code, the byte read from the addressed file, an 8-bit constant, a 3-bit bit selector, a one-bit destination choice and the file address. In the same cycle the unit forms the result byte, says whether that byte goes to the file store (`file_we`, `file_wdata`), and raises `skip_req` when a conditional-skip operation finds its condition true. The working register W and the status byte are held inside the unit and update on the clock edge that ends the operation.

The unit has no sequencing of its own. Its whole state is two registers: the W register and the status byte. Carry sits in bit 0 of the status byte and zero in bit 2. Every cycle with `op_valid` high is one transition of that state, named by its operation code. A cycle with `op_valid` low is the hold transition, which leaves both registers as they were. A file write that targets the status file's address (3 by default) replaces the whole status byte. That write wins over any flag update from the same operation.

Top module: `acc_exec_unit`

## Requirements
- R1: After reset, W and the status byte read 0x00, and with `op_valid` low `file_we` and `skip_req` are 0.
- R2: Add forms update both carry and zero. The file form is code 0 (W+file) and the literal form is code 1 (W+literal). The result is the low 8 bits of the sum, status bit 0 (C) takes the carry out of bit 7, and status bit 2 (Z) is set exactly when the result is 0x00.
- R3: Subtract forms update both C and Z, with C=1 when there is no borrow and C=0 when a borrow occurs. Code 2 computes file−W. Code 3 computes literal−W, not W−literal.
- R4: Logic operations update Z only and leave C unchanged. AND is code 4 (file) and 5 (literal). Inclusive OR is code 6 and 7. Exclusive OR is code 8 and 9.
- R5: When the destination bit is 0 the result goes to W. When it is 1, `file_we` is asserted with `file_wdata` equal to the result. Literal forms (codes 1, 3, 5, 7, 9) always write W and never the file. No operation writes both.
- R6: These operations update Z only: clear-file (code 10, always writes the file), clear-W (code 11, always writes W), complement (12), increment (13), decrement (14) and move-file (17). Codes 12, 13, 14 and 17 follow the destination bit.
- R7: Rotate left (code 15) and rotate right (code 16) go through carry. The bit shifted out lands in C and the old C fills the vacated end. Only C is updated; Z keeps its value.
- R8: Move-W-to-file (code 18) writes W to the file. Move-literal (code 19) loads the literal into W. Neither changes C or Z.
- R9: Bit test uses the file bit chosen by `bit_sel`. Code 20 asserts `skip_req` when that bit is 0, and code 21 asserts it when the bit is 1. Neither writes anything or changes a flag.
- R10: Increment-skip (code 22) and decrement-skip (code 23) produce file±1, follow the destination bit, assert `skip_req` exactly when the new value is 0x00, and leave C and Z unchanged.
- R11: When `file_we` is asserted with `file_addr` equal to the status address (3), the status byte takes `file_wdata` whole, overriding that operation's flag updates.
- R12: With `op_valid` low, `file_we` and `skip_req` stay 0 and W and the status byte hold.
- R13: Code 24 (no-op) and the unused codes 25 to 31 write nothing, raise no skip, and leave W and the status byte unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | An operation is presented this cycle |
| op_code | input | 5 | Decoded operation code |
| file_addr | input | 7 | Address of the file operand and write target |
| file_rdata | input | 8 | Byte read from the addressed file |
| literal | input | 8 | Constant operand |
| bit_sel | input | 3 | Bit selector for bit tests |
| dest_file | input | 1 | 0: result to W, 1: result to the file |
| file_we | output | 1 | Write the result to the addressed file |
| file_wdata | output | 8 | Result byte |
| skip_req | output | 1 | Skip the next instruction |
| w_reg | output | 8 | Working register W |
| status_reg | output | 8 | Status byte: C in bit 0, Z in bit 2 |

## Verification
A wrong W value or a wrong flag shows up on `w_reg` or `status_reg` one edge after the operation that produced it. A wrong carry also spreads: it changes the next rotate's result at `file_wdata` in the same cycle that rotate is issued. Destination and skip faults are combinational, so they are visible at `file_we` and `skip_req` before the edge of the faulty operation itself. Each swept vector loads a fresh status byte and W, runs one operation, and compares both the combinational outputs and the registers after the edge. A fault is therefore localised to the single operation that caused it.

// File: rtl/exu_pkg.sv
package exu_pkg;

    typedef enum logic [4:0] {
        OP_ADDWF  = 5'd0,
        OP_ADDLW  = 5'd1,
        OP_SUBWF  = 5'd2,
        OP_SUBLW  = 5'd3,
        OP_ANDWF  = 5'd4,
        OP_ANDLW  = 5'd5,
        OP_IORWF  = 5'd6,
        OP_IORLW  = 5'd7,
        OP_XORWF  = 5'd8,
        OP_XORLW  = 5'd9,
        OP_CLRF   = 5'd10,
        OP_CLRW   = 5'd11,
        OP_COMF   = 5'd12,
        OP_INCF   = 5'd13,
        OP_DECF   = 5'd14,
        OP_RLF    = 5'd15,
        OP_RRF    = 5'd16,
        OP_MOVF   = 5'd17,
        OP_MOVWF  = 5'd18,
        OP_MOVLW  = 5'd19,
        OP_BTSKC  = 5'd20,
        OP_BTSKS  = 5'd21,
        OP_INCSKZ = 5'd22,
        OP_DECSKZ = 5'd23,
        OP_NOP    = 5'd24
    } exu_op_e;

    typedef struct packed {
        logic wr_w;
        logic wr_f;
        logic upd_c;
        logic upd_z;
        logic skip;
    } exu_ctl_t;

endpackage

// File: rtl/exu_alu.sv
module exu_alu
    import exu_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned BIT_W  = $clog2(DATA_W)
) (
    input  logic [4:0]        op_code,
    input  logic [DATA_W-1:0] w_val,
    input  logic [DATA_W-1:0] f_val,
    input  logic [DATA_W-1:0] lit_val,
    input  logic [BIT_W-1:0]  bit_idx,
    input  logic              dest_f,
    input  logic              c_in,
    output logic [DATA_W-1:0] res,
    output logic              c_out,
    output exu_ctl_t          ctl
);

    localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

    logic follow_dest;

    always_comb begin
        res         = '0;
        c_out       = c_in;
        ctl         = '0;
        follow_dest = 1'b0;
        unique case (op_code)
            OP_ADDWF: begin
                {c_out, res} = {1'b0, w_val} + {1'b0, f_val};
                follow_dest = 1'b1; ctl.upd_c = 1'b1; ctl.upd_z = 1'b1;
            end
            OP_ADDLW: begin
                {c_out, res} = {1'b0, w_val} + {1'b0, lit_val};
                ctl.wr_w = 1'b1; ctl.upd_c = 1'b1; ctl.upd_z = 1'b1;
            end
            OP_SUBWF: begin
                {c_out, res} = {1'b0, f_val} + {1'b0, ~w_val} + (DATA_W+1)'(1);
                follow_dest = 1'b1; ctl.upd_c = 1'b1; ctl.upd_z = 1'b1;
            end
            OP_SUBLW: begin
                {c_out, res} = {1'b0, lit_val} + {1'b0, ~w_val} + (DATA_W+1)'(1);
                ctl.wr_w = 1'b1; ctl.upd_c = 1'b1; ctl.upd_z = 1'b1;
            end
            OP_ANDWF: begin res = w_val & f_val;   follow_dest = 1'b1; ctl.upd_z = 1'b1; end
            OP_ANDLW: begin res = w_val & lit_val; ctl.wr_w = 1'b1;    ctl.upd_z = 1'b1; end
            OP_IORWF: begin res = w_val | f_val;   follow_dest = 1'b1; ctl.upd_z = 1'b1; end
            OP_IORLW: begin res = w_val | lit_val; ctl.wr_w = 1'b1;    ctl.upd_z = 1'b1; end
            OP_XORWF: begin res = w_val ^ f_val;   follow_dest = 1'b1; ctl.upd_z = 1'b1; end
            OP_XORLW: begin res = w_val ^ lit_val; ctl.wr_w = 1'b1;    ctl.upd_z = 1'b1; end
            OP_CLRF:  begin res = '0;              ctl.wr_f = 1'b1;    ctl.upd_z = 1'b1; end
            OP_CLRW:  begin res = '0;              ctl.wr_w = 1'b1;    ctl.upd_z = 1'b1; end
            OP_COMF:  begin res = ~f_val;          follow_dest = 1'b1; ctl.upd_z = 1'b1; end
            OP_INCF:  begin res = f_val + ONE;     follow_dest = 1'b1; ctl.upd_z = 1'b1; end
            OP_DECF:  begin res = f_val - ONE;     follow_dest = 1'b1; ctl.upd_z = 1'b1; end
            OP_RLF: begin
                res   = {f_val[DATA_W-2:0], c_in};
                c_out = f_val[DATA_W-1];
                follow_dest = 1'b1; ctl.upd_c = 1'b1;
            end
            OP_RRF: begin
                res   = {c_in, f_val[DATA_W-1:1]};
                c_out = f_val[0];
                follow_dest = 1'b1; ctl.upd_c = 1'b1;
            end
            OP_MOVF:  begin res = f_val;   follow_dest = 1'b1; ctl.upd_z = 1'b1; end
            OP_MOVWF: begin res = w_val;   ctl.wr_f = 1'b1; end
            OP_MOVLW: begin res = lit_val; ctl.wr_w = 1'b1; end
            OP_BTSKC: begin res = f_val;   ctl.skip = ~f_val[bit_idx]; end
            OP_BTSKS: begin res = f_val;   ctl.skip =  f_val[bit_idx]; end
            OP_INCSKZ: begin
                res = f_val + ONE;
                follow_dest = 1'b1; ctl.skip = (res == '0);
            end
            OP_DECSKZ: begin
                res = f_val - ONE;
                follow_dest = 1'b1; ctl.skip = (res == '0);
            end
            default: begin
                res = '0;
            end
        endcase
        if (follow_dest) begin
            ctl.wr_w = ~dest_f;
            ctl.wr_f =  dest_f;
        end
    end

endmodule

// File: rtl/exu_status.sv
module exu_status #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned C_BIT  = 0,
    parameter int unsigned Z_BIT  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_status,
    input  logic [DATA_W-1:0] wdata,
    input  logic              upd_c,
    input  logic              c_new,
    input  logic              upd_z,
    input  logic              z_new,
    output logic [DATA_W-1:0] stat_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_q <= '0;
        end else if (wr_status) begin
            stat_q <= wdata;
        end else begin
            if (upd_c) stat_q[C_BIT] <= c_new;
            if (upd_z) stat_q[Z_BIT] <= z_new;
        end
    end

    assert_status_write_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_status |=> stat_q == $past(wdata));

    assert_c_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_status && !upd_c) |=> stat_q[C_BIT] == $past(stat_q[C_BIT]));

    assert_z_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_status && !upd_z) |=> stat_q[Z_BIT] == $past(stat_q[Z_BIT]));

endmodule

// File: rtl/acc_exec_unit.sv
module acc_exec_unit
    import exu_pkg::*;
#(
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned ADDR_W      = 7,
    parameter int unsigned STATUS_ADDR = 3,
    parameter int unsigned C_BIT       = 0,
    parameter int unsigned Z_BIT       = 2,
    parameter int unsigned BIT_W       = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [4:0]        op_code,
    input  logic [ADDR_W-1:0] file_addr,
    input  logic [DATA_W-1:0] file_rdata,
    input  logic [DATA_W-1:0] literal,
    input  logic [BIT_W-1:0]  bit_sel,
    input  logic              dest_file,
    output logic              file_we,
    output logic [DATA_W-1:0] file_wdata,
    output logic              skip_req,
    output logic [DATA_W-1:0] w_reg,
    output logic [DATA_W-1:0] status_reg
);

    localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STATUS_ADDR);

    logic [DATA_W-1:0] w_q;
    logic [DATA_W-1:0] alu_res;
    logic              alu_c;
    exu_ctl_t          ctl;
    logic              w_we;
    logic              status_hit;

    exu_alu #(.DATA_W(DATA_W), .BIT_W(BIT_W)) u_alu (
        .op_code (op_code),
        .w_val   (w_q),
        .f_val   (file_rdata),
        .lit_val (literal),
        .bit_idx (bit_sel),
        .dest_f  (dest_file),
        .c_in    (status_reg[C_BIT]),
        .res     (alu_res),
        .c_out   (alu_c),
        .ctl     (ctl)
    );

    assign w_we       = op_valid & ctl.wr_w;
    assign file_we    = op_valid & ctl.wr_f;
    assign skip_req   = op_valid & ctl.skip;
    assign file_wdata = alu_res;
    assign status_hit = file_we & (file_addr == STAT_A);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            w_q <= '0;
        end else if (w_we) begin
            w_q <= alu_res;
        end
    end

    assign w_reg = w_q;

    exu_status #(.DATA_W(DATA_W), .C_BIT(C_BIT), .Z_BIT(Z_BIT)) u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_status (status_hit),
        .wdata     (alu_res),
        .upd_c     (op_valid & ctl.upd_c),
        .c_new     (alu_c),
        .upd_z     (op_valid & ctl.upd_z),
        .z_new     (alu_res == '0),
        .stat_q    (status_reg)
    );

    assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |-> (!file_we && !skip_req));

    assert_idle_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> ($stable(w_reg) && $stable(status_reg)));

    assert_one_target_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(w_we && file_we));

    assert_skip_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
        skip_req |-> (op_code >= 5'(OP_BTSKC) && op_code <= 5'(OP_DECSKZ)));

    assert_w_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !w_we |=> $stable(w_reg));

endmodule

// File: tb/sim_acc_exec_unit.sv
module sim_acc_exec_unit;
    import exu_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_valid = 1'b0;
    logic [4:0] op_code = '0;
    logic [6:0] file_addr = '0;
    logic [7:0] file_rdata = '0;
    logic [7:0] literal = '0;
    logic [2:0] bit_sel = '0;
    logic       dest_file = 1'b0;
    logic       file_we;
    logic [7:0] file_wdata;
    logic       skip_req;
    logic [7:0] w_reg;
    logic [7:0] status_reg;

    int n_tests = 0;
    int n_fail  = 0;
    logic [7:0] vals [16];

    always #4 clk = ~clk;

    acc_exec_unit u0 (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .file_addr(file_addr), .file_rdata(file_rdata), .literal(literal),
        .bit_sel(bit_sel), .dest_file(dest_file), .file_we(file_we),
        .file_wdata(file_wdata), .skip_req(skip_req), .w_reg(w_reg),
        .status_reg(status_reg)
    );

    task automatic check(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
        end
    endtask

    function automatic string tag(input int op);
        case (op)
            0, 1:            return "R2";
            2, 3:            return "R3";
            4, 6, 8:         return "R4";
            5, 7, 9:         return "R5";
            10, 11, 12, 13, 14, 17: return "R6";
            15, 16:          return "R7";
            18, 19:          return "R8";
            20, 21:          return "R9";
            22, 23:          return "R10";
            default:         return "R13";
        endcase
    endfunction

    task automatic model(input int op, input logic [7:0] w, f, l, s, input int b, input bit d,
                         output logic [7:0] r, output bit ww, output bit wf, output bit sk,
                         output logic [7:0] ew, output logic [7:0] es);
        int t;
        bit c, uc, uz, dd;
        r = 8'h00; ww = 0; wf = 0; sk = 0; uc = 0; uz = 0; dd = 0; c = s[0];
        case (op)
            0:  begin t = w + f; r = 8'(t); c = (t > 255); uc = 1; uz = 1; dd = 1; end
            1:  begin t = w + l; r = 8'(t); c = (t > 255); uc = 1; uz = 1; ww = 1; end
            2:  begin r = 8'(int'(f) - int'(w)); c = (f >= w); uc = 1; uz = 1; dd = 1; end
            3:  begin r = 8'(int'(l) - int'(w)); c = (l >= w); uc = 1; uz = 1; ww = 1; end
            4:  begin r = w & f; uz = 1; dd = 1; end
            5:  begin r = w & l; uz = 1; ww = 1; end
            6:  begin r = w | f; uz = 1; dd = 1; end
            7:  begin r = w | l; uz = 1; ww = 1; end
            8:  begin r = w ^ f; uz = 1; dd = 1; end
            9:  begin r = w ^ l; uz = 1; ww = 1; end
            10: begin r = 0; uz = 1; wf = 1; end
            11: begin r = 0; uz = 1; ww = 1; end
            12: begin r = ~f; uz = 1; dd = 1; end
            13: begin r = 8'(f + 1); uz = 1; dd = 1; end
            14: begin r = 8'(int'(f) - 1); uz = 1; dd = 1; end
            15: begin r = {f[6:0], s[0]}; c = f[7]; uc = 1; dd = 1; end
            16: begin r = {s[0], f[7:1]}; c = f[0]; uc = 1; dd = 1; end
            17: begin r = f; uz = 1; dd = 1; end
            18: begin r = w; wf = 1; end
            19: begin r = l; ww = 1; end
            20: sk = (f[b] == 1'b0);
            21: sk = (f[b] == 1'b1);
            22: begin r = 8'(f + 1); dd = 1; sk = (r == 0); end
            23: begin r = 8'(int'(f) - 1); dd = 1; sk = (r == 0); end
            default: ;
        endcase
        if (dd) begin ww = !d; wf = d; end
        ew = ww ? r : w;
        es = s;
        if (uc) es[0] = c;
        if (uz) es[2] = (r == 0);
    endtask

    task automatic drive(input int op, input logic [7:0] f, l, input int b, input bit d,
                         input logic [6:0] a, input bit v);
        @(negedge clk);
        op_valid = v; op_code = 5'(op); file_rdata = f; literal = l;
        bit_sel = 3'(b); dest_file = d; file_addr = a;
    endtask

    task automatic issue(input int op, input logic [7:0] l, input logic [6:0] a);
        drive(op, 8'h00, l, 0, 1'b0, a, 1'b1);
        @(posedge clk); #1;
    endtask

    task automatic preset(input logic [7:0] s, input logic [7:0] w);
        issue(19, s, 7'd5);
        issue(18, 8'h00, 7'd3);
        issue(19, w, 7'd5);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] r, ew, es, s, w, f, w0, s0;
        bit ww, wf, sk;
        int b;
        vals = '{8'h00, 8'h01, 8'h02, 8'h05, 8'h07, 8'h09, 8'h0F, 8'h10,
                 8'h7F, 8'h80, 8'h81, 8'hAA, 8'h55, 8'hFE, 8'hFF, 8'h3C};

        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        check("R1", "w_reg", w_reg, 8'h00);
        check("R1", "status", status_reg, 8'h00);
        check("R1", "file_we", {7'd0, file_we}, 8'h00);
        check("R1", "skip", {7'd0, skip_req}, 8'h00);

        // sweep all codes over operand grid, both destinations
        for (int op = 0; op < 32; op++) begin
            for (int i = 0; i < 16; i++) begin
                for (int j = 0; j < 16; j++) begin
                    for (int d = 0; d < 2; d++) begin
                        s = 8'(i * 29 + j * 7 + d * 3 + op);
                        w = vals[i];
                        f = vals[j];
                        b = (i + j * 3) % 8;
                        preset(s, w);
                        model(op, w, f, f, s, b, d[0], r, ww, wf, sk, ew, es);
                        drive(op, f, f, b, d[0], 7'd5, 1'b1);
                        #1;
                        check(tag(op), "file_we", {7'd0, file_we}, {7'd0, wf});
                        check(tag(op), "skip", {7'd0, skip_req}, {7'd0, sk});
                        if (wf) check(tag(op), "file_wdata", file_wdata, r);
                        @(posedge clk); #1;
                        check(tag(op), "w_reg", w_reg, ew);
                        check(tag(op), "status", status_reg, es);
                    end
                end
            end
        end

        // R11: result written to the status file beats flag update
        preset(8'h00, 8'h80);
        drive(0, 8'h80, 8'h00, 0, 1'b1, 7'd3, 1'b1);
        #1;
        check("R11", "file_wdata", file_wdata, 8'h00);
        @(posedge clk); #1;
        check("R11", "status add", status_reg, 8'h00);
        drive(13, 8'h44, 8'h00, 0, 1'b1, 7'd3, 1'b1);
        @(posedge clk); #1;
        check("R11", "status inc", status_reg, 8'h45);
        drive(16, 8'h01, 8'h00, 0, 1'b1, 7'd3, 1'b1);
        @(posedge clk); #1;
        check("R11", "status rrf", status_reg, 8'h80);

        // R12: op_valid low has no effect
        preset(8'h01, 8'h33);
        w0 = w_reg; s0 = status_reg;
        drive(0, 8'hFF, 8'h00, 0, 1'b1, 7'd5, 1'b0);
        #1;
        check("R12", "file_we", {7'd0, file_we}, 8'h00);
        @(posedge clk); #1;
        drive(21, 8'hFF, 8'h00, 3, 1'b0, 7'd5, 1'b0);
        #1;
        check("R12", "skip", {7'd0, skip_req}, 8'h00);
        @(posedge clk); #1;
        drive(11, 8'h00, 8'h00, 0, 1'b0, 7'd5, 1'b0);
        @(posedge clk); #1;
        check("R12", "w_reg", w_reg, w0);
        check("R12", "status", status_reg, s0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule